// File: doc/BRIEF.md
# PTP Event Timestamp Capture Unit

This block sits beside one Ethernet port and watches two byte streams: frames being received and frames being transmitted. Each frame is presented from the first destination-address byte onward. When a frame is addressed to one of the enabled PTP multicast destinations and carries the event message that the port's role selects for that direction, the block stores a timestamp, the sender's source identity and the sequence number. The stored values are held in one capture register per direction, and each capture raises that direction's interrupt flag.

The timestamp is taken from a free-running clock input on the cycle that carries the frame's first byte. It is only committed once the whole header has been seen and has matched. A role bit picks master or slave behaviour. Five enables select which destination addresses are treated as PTP: four fixed multicast addresses and one programmable address. A lock per direction can keep unread captured data from being overwritten. Software-style configuration arrives through two write strobes. Each interrupt flag has its own write-one-to-clear pulse.

Both byte streams use valid/ready. The block never applies back-pressure: each ready output is held high, and a byte is consumed on every cycle where valid is high. A source may leave gaps by dropping valid, and no byte is lost while valid is low.

Top module: `ptp_evt_capture`

## Requirements
- R1: With the role bit (configuration bit 0) set, a transmitted Sync and a received Delay_Req are captured, and a received Sync is ignored.
- R2: With the role bit clear, a transmitted Delay_Req and a received Sync are captured, and a transmitted Sync is ignored.
- R3: A frame counts only if its 48-bit destination address matches an enabled entry. The entries and their enable bits are 01:00:5E:00:01:81 (bit 3), 01:00:5E:00:01:82 (bit 4), 01:00:5E:00:01:83 (bit 5), 01:00:5E:00:01:84 (bit 6), and the programmed auxiliary address (bit 7). Any other destination is ignored.
- R4: After reset the configuration byte is 0x0E: slave role, RX lock (bit 1) on, TX lock (bit 2) on, and only the first fixed address enabled. The auxiliary address is zero, both flags are low and all capture fields are zero.
- R5: A capture stores three values. The timestamp is the clock input on the cycle of the first frame byte. The source identity is header bytes 20 to 29 (first byte most significant). The sequence number is header bytes 30 to 31, big-endian. The outputs show the new values two cycles after the last sequence byte is accepted.
- R6: Each capture sets its direction's flag. A clear pulse drops the flag one cycle later. A capture in the same cycle as a clear wins, and the flag stays set.
- R7: While a direction's lock is on and its flag is set, a further matching frame leaves the stored timestamp, identity and sequence unchanged.
- R8: With the lock off, a later matching frame overwrites all stored values and the flag stays set.
- R9: The message type is the low nibble of header byte 0: 0 is Sync, 1 is Delay_Req, and any other value is ignored. A frame cut short by a new start-of-frame is never captured.
- R10: Ready is always high. The PTP header begins at frame byte 14, and the start-of-frame strobe marks destination-address byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_in | input | TS_W | Free-running time value |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte: role, locks, address enables |
| aux_we | input | 1 | Auxiliary address write strobe |
| aux_wdata | input | 48 | Auxiliary destination address |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte ready, always high |
| rx_sof | input | 1 | Receive first-byte marker |
| rx_data | input | 8 | Receive frame byte |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit byte ready, always high |
| tx_sof | input | 1 | Transmit first-byte marker |
| tx_data | input | 8 | Transmit frame byte |
| rx_irq_clr | input | 1 | Write-one-to-clear for the receive flag |
| tx_irq_clr | input | 1 | Write-one-to-clear for the transmit flag |
| rx_irq | output | 1 | Receive capture flag |
| tx_irq | output | 1 | Transmit capture flag |
| rx_cap_ts | output | TS_W | Receive captured timestamp |
| rx_cap_srcid | output | 80 | Receive captured source identity |
| rx_cap_seq | output | 16 | Receive captured sequence number |
| tx_cap_ts | output | TS_W | Transmit captured timestamp |
| tx_cap_srcid | output | 80 | Transmit captured source identity |
| tx_cap_seq | output | 16 | Transmit captured sequence number |

## Verification
Sync and Delay_Req frames are sent in each direction under both roles. These show whether the trigger swaps correctly per direction, and a wrong-role message must leave the flag low. Each address enable is tried on its own against its matching address and against the default address. This separates a filter that checks the right entry from one that accepts any enabled entry, and a non-matching address and a non-event type confirm rejection. Back-to-back matching frames with the lock on and with it off separate holding from overwriting. A clear that coincides with a capture, together with a truncated frame, probes the flag priority and the commit point.

// File: rtl/ptp_cap_pkg.sv
package ptp_cap_pkg;
  localparam int SRCID_BYTES = 10;
  localparam int SRCID_W     = SRCID_BYTES * 8;
  localparam int SEQ_W       = 16;
  localparam int ADDR_W      = 48;
  localparam int N_FIXED     = 4;
  localparam int N_ADDR_EN   = N_FIXED + 1;
  localparam logic [ADDR_W-1:0] MCAST_BASE = 48'h01005E000181;
  localparam logic [7:0] CFG_RESET = 8'h0E;

  typedef enum logic [3:0] {
    MSG_SYNC      = 4'h0,
    MSG_DELAY_REQ = 4'h1
  } ptp_msg_e;

  typedef struct packed {
    logic       aux_en;
    logic [2:0] alt_en;
    logic       pri_en;
    logic       lock_tx;
    logic       lock_rx;
    logic       master;
  } cap_cfg_t;
endpackage

// File: rtl/ptp_cap_cfg.sv
module ptp_cap_cfg
  import ptp_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              aux_we,
  input  logic [ADDR_W-1:0] aux_wdata,
  output cap_cfg_t          cfg,
  output logic [ADDR_W-1:0] aux_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= cap_cfg_t'(CFG_RESET);
      aux_addr <= '0;
    end else begin
      if (cfg_we) cfg      <= cap_cfg_t'(cfg_wdata);
      if (aux_we) aux_addr <= aux_wdata;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg)); // R4
endmodule

// File: rtl/ptp_frame_parser.sv
module ptp_frame_parser
  import ptp_cap_pkg::*;
#(
  parameter int TS_W    = 64,
  parameter int HDR_OFS = 14,
  parameter bit IS_TX   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  input  logic                 s_sof,
  input  logic [7:0]           s_data,
  input  logic [TS_W-1:0]      ts_in,
  input  logic                 master,
  input  logic [N_ADDR_EN-1:0] addr_en,
  input  logic [ADDR_W-1:0]    aux_addr,
  output logic                 hit,
  output logic [TS_W-1:0]      hit_ts,
  output logic [SRCID_W-1:0]   hit_srcid,
  output logic [SEQ_W-1:0]     hit_seq
);
  localparam int SRC_OFS = HDR_OFS + 20;
  localparam int SEQ_OFS = HDR_OFS + 30;
  localparam int LAST    = HDR_OFS + 31;
  localparam int CW      = $clog2(LAST + 2);
  localparam logic [CW-1:0] IDX_DA_END  = CW'(6);
  localparam logic [CW-1:0] IDX_HDR     = CW'(HDR_OFS);
  localparam logic [CW-1:0] IDX_SRC     = CW'(SRC_OFS);
  localparam logic [CW-1:0] IDX_SRC_END = CW'(SRC_OFS + SRCID_BYTES);
  localparam logic [CW-1:0] IDX_SEQ     = CW'(SEQ_OFS);
  localparam logic [CW-1:0] IDX_LAST    = CW'(LAST);

  logic                active;
  logic [CW-1:0]       idx;
  logic [ADDR_W-1:0]   da;
  logic [3:0]          mtype;
  logic [SRCID_W-1:0]  srcid;
  logic [7:0]          seq_hi;
  logic [TS_W-1:0]     ts_hold;
  logic                addr_ok;
  logic                type_ok;
  ptp_msg_e            want;

  always_comb begin
    addr_ok = addr_en[N_FIXED] && (da == aux_addr);
    for (int k = 0; k < N_FIXED; k++)
      if (addr_en[k] && (da == MCAST_BASE + ADDR_W'(k))) addr_ok = 1'b1;
  end

  // Master: TX Sync / RX Delay_Req. Slave: the other way round.
  assign want    = (master == IS_TX) ? MSG_SYNC : MSG_DELAY_REQ;
  assign type_ok = (mtype == want);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      idx       <= '0;
      da        <= '0;
      mtype     <= '0;
      srcid     <= '0;
      seq_hi    <= '0;
      ts_hold   <= '0;
      hit       <= 1'b0;
      hit_ts    <= '0;
      hit_srcid <= '0;
      hit_seq   <= '0;
    end else begin
      hit <= 1'b0;
      if (s_valid) begin
        if (s_sof) begin
          active  <= 1'b1;
          idx     <= CW'(1);
          da      <= {{(ADDR_W-8){1'b0}}, s_data};
          ts_hold <= ts_in;
        end else if (active) begin
          idx <= idx + CW'(1);
          if (idx < IDX_DA_END) da <= {da[ADDR_W-9:0], s_data};
          if (idx == IDX_HDR) mtype <= s_data[3:0];
          if (idx >= IDX_SRC && idx < IDX_SRC_END)
            srcid <= {srcid[SRCID_W-9:0], s_data};
          if (idx == IDX_SEQ) seq_hi <= s_data;
          if (idx == IDX_LAST) begin
            active    <= 1'b0;
            hit       <= addr_ok && type_ok;
            hit_ts    <= ts_hold;
            hit_srcid <= srcid;
            hit_seq   <= {seq_hi, s_data};
          end
        end
      end
    end
  end

  AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R5
  AST_HIT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> !hit); // R10
endmodule

// File: rtl/ptp_cap_store.sv
module ptp_cap_store
  import ptp_cap_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [TS_W-1:0]    hit_ts,
  input  logic [SRCID_W-1:0] hit_srcid,
  input  logic [SEQ_W-1:0]   hit_seq,
  input  logic               lock_en,
  input  logic               clr,
  output logic               irq,
  output logic [TS_W-1:0]    cap_ts,
  output logic [SRCID_W-1:0] cap_srcid,
  output logic [SEQ_W-1:0]   cap_seq
);
  logic write_ok;
  assign write_ok = hit && !(lock_en && irq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      cap_ts    <= '0;
      cap_srcid <= '0;
      cap_seq   <= '0;
    end else begin
      if (hit)      irq <= 1'b1;
      else if (clr) irq <= 1'b0;
      if (write_ok) begin
        cap_ts    <= hit_ts;
        cap_srcid <= hit_srcid;
        cap_seq   <= hit_seq;
      end
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !irq); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lock_en && irq) |=> ($stable(cap_ts) && $stable(cap_srcid) && $stable(cap_seq))); // R7
  AST_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lock_en) |=> (cap_seq == $past(hit_seq) && cap_ts == $past(hit_ts))); // R8
endmodule

// File: rtl/ptp_evt_capture.sv
module ptp_evt_capture
  import ptp_cap_pkg::*;
#(
  parameter int TS_W    = 64,
  parameter int HDR_OFS = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TS_W-1:0]    ts_in,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  input  logic               aux_we,
  input  logic [47:0]        aux_wdata,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic               rx_sof,
  input  logic [7:0]         rx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic               tx_sof,
  input  logic [7:0]         tx_data,
  input  logic               rx_irq_clr,
  input  logic               tx_irq_clr,
  output logic               rx_irq,
  output logic               tx_irq,
  output logic [TS_W-1:0]    rx_cap_ts,
  output logic [79:0]        rx_cap_srcid,
  output logic [15:0]        rx_cap_seq,
  output logic [TS_W-1:0]    tx_cap_ts,
  output logic [79:0]        tx_cap_srcid,
  output logic [15:0]        tx_cap_seq
);
  localparam int N_DIR = 2;

  cap_cfg_t          cfg;
  logic [ADDR_W-1:0] aux_addr;
  logic [N_ADDR_EN-1:0] addr_en;

  logic               d_valid [N_DIR];
  logic               d_sof   [N_DIR];
  logic [7:0]         d_data  [N_DIR];
  logic               d_clr   [N_DIR];
  logic               d_lock  [N_DIR];
  logic               d_irq   [N_DIR];
  logic [TS_W-1:0]    d_ts    [N_DIR];
  logic [SRCID_W-1:0] d_srcid [N_DIR];
  logic [SEQ_W-1:0]   d_seq   [N_DIR];

  assign rx_ready = 1'b1;
  assign tx_ready = 1'b1;
  assign addr_en  = {cfg.aux_en, cfg.alt_en, cfg.pri_en};

  assign d_valid[0] = rx_valid;   assign d_valid[1] = tx_valid;
  assign d_sof[0]   = rx_sof;     assign d_sof[1]   = tx_sof;
  assign d_data[0]  = rx_data;    assign d_data[1]  = tx_data;
  assign d_clr[0]   = rx_irq_clr; assign d_clr[1]   = tx_irq_clr;
  assign d_lock[0]  = cfg.lock_rx;
  assign d_lock[1]  = cfg.lock_tx;

  assign rx_irq = d_irq[0];  assign rx_cap_ts = d_ts[0];
  assign rx_cap_srcid = d_srcid[0];  assign rx_cap_seq = d_seq[0];
  assign tx_irq = d_irq[1];  assign tx_cap_ts = d_ts[1];
  assign tx_cap_srcid = d_srcid[1];  assign tx_cap_seq = d_seq[1];

  ptp_cap_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .aux_we(aux_we), .aux_wdata(aux_wdata), .cfg(cfg), .aux_addr(aux_addr)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    logic               hit;
    logic [TS_W-1:0]    hit_ts;
    logic [SRCID_W-1:0] hit_srcid;
    logic [SEQ_W-1:0]   hit_seq;

    ptp_frame_parser #(.TS_W(TS_W), .HDR_OFS(HDR_OFS), .IS_TX(d == 1)) u_parse (
      .clk(clk), .rst_n(rst_n), .s_valid(d_valid[d]), .s_sof(d_sof[d]),
      .s_data(d_data[d]), .ts_in(ts_in), .master(cfg.master),
      .addr_en(addr_en), .aux_addr(aux_addr), .hit(hit), .hit_ts(hit_ts),
      .hit_srcid(hit_srcid), .hit_seq(hit_seq)
    );

    ptp_cap_store #(.TS_W(TS_W)) u_store (
      .clk(clk), .rst_n(rst_n), .hit(hit), .hit_ts(hit_ts),
      .hit_srcid(hit_srcid), .hit_seq(hit_seq), .lock_en(d_lock[d]),
      .clr(d_clr[d]), .irq(d_irq[d]), .cap_ts(d_ts[d]),
      .cap_srcid(d_srcid[d]), .cap_seq(d_seq[d])
    );
  end

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && tx_ready); // R10
endmodule

// File: tb/tb_ptp_evt_capture.sv
module tb_ptp_evt_capture;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] A_PRI  = 48'h01005E000181;
  localparam logic [47:0] A_ALT1 = 48'h01005E000182;
  localparam logic [47:0] A_ALT2 = 48'h01005E000183;
  localparam logic [47:0] A_ALT3 = 48'h01005E000184;
  localparam logic [47:0] A_AUX  = 48'h0A1B2C3D4E5F;
  localparam logic [3:0] T_SYNC = 4'h0, T_DREQ = 4'h1;

  logic clk = 0, rst_n = 0;
  logic [63:0] ts_in = '0;
  logic cfg_we = 0, aux_we = 0;
  logic [7:0] cfg_wdata = '0;
  logic [47:0] aux_wdata = '0;
  logic rx_valid = 0, rx_sof = 0, tx_valid = 0, tx_sof = 0;
  logic [7:0] rx_data = '0, tx_data = '0;
  logic rx_ready, tx_ready;
  logic rx_irq_clr = 0, tx_irq_clr = 0;
  logic rx_irq, tx_irq;
  logic [63:0] rx_cap_ts, tx_cap_ts;
  logic [79:0] rx_cap_srcid, tx_cap_srcid;
  logic [15:0] rx_cap_seq, tx_cap_seq;

  int checks = 0, failures = 0;
  bit done = 0;

  ptp_evt_capture dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); rx_irq_clr = 1; tx_irq_clr = 1;
    @(negedge clk); rx_irq_clr = 0; tx_irq_clr = 0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [47:0] da,
      input logic [3:0] mt, input logic [79:0] sid, input logic [15:0] seq);
    if (i < 6)        return da[8*(5-i) +: 8];
    else if (i == 14) return {4'hA, mt};
    else if (i >= 34 && i < 44) return sid[8*(43-i) +: 8];
    else if (i == 44) return seq[15:8];
    else if (i == 45) return seq[7:0];
    else              return 8'(i * 7 + 3);
  endfunction

  // Sends nb bytes; optional clear pulse lands in the commit cycle.
  task automatic send(input bit tx, input logic [47:0] da, input logic [3:0] mt,
      input logic [79:0] sid, input logic [15:0] seq, input logic [63:0] base,
      input int nb = 46, input bit clr_commit = 0);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      ts_in = base + 64'(i);
      if (tx) begin tx_valid = 1; tx_sof = (i == 0); tx_data = fbyte(i, da, mt, sid, seq); end
      else    begin rx_valid = 1; rx_sof = (i == 0); rx_data = fbyte(i, da, mt, sid, seq); end
    end
    @(negedge clk);
    rx_valid = 0; tx_valid = 0; rx_sof = 0; tx_sof = 0;
    if (clr_commit) begin if (tx) tx_irq_clr = 1; else rx_irq_clr = 1; end
    @(negedge clk); rx_irq_clr = 0; tx_irq_clr = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R4 rx_irq", rx_irq, 0);
    check("R4 tx_irq", tx_irq, 0);
    check("R4 rx_ts", rx_cap_ts, 0);
    check("R4 tx_seq", tx_cap_seq, 0);
    check("R10 ready", {rx_ready, tx_ready}, 2'b11);
  endtask

  task automatic t_slave_default();
    send(0, A_PRI, T_SYNC, 80'h11223344556677889900, 16'h1234, 64'h1000);
    check("R2 rx sync irq", rx_irq, 1);
    check("R5 rx ts", rx_cap_ts, 64'h1000);
    check("R5 rx srcid", rx_cap_srcid, 80'h11223344556677889900);
    check("R5 rx seq", rx_cap_seq, 16'h1234);
    send(1, A_PRI, T_DREQ, 80'hAA, 16'h0042, 64'h2000);
    check("R2 tx dreq irq", tx_irq, 1);
    check("R2 tx seq", tx_cap_seq, 16'h0042);
    clear_flags();
    check("R6 rx cleared", rx_irq, 0);
    check("R6 tx cleared", tx_irq, 0);
    send(1, A_PRI, T_SYNC, 80'hBB, 16'h0043, 64'h2100);
    check("R2 tx sync ignored irq", tx_irq, 0);
    check("R2 tx sync ignored seq", tx_cap_seq, 16'h0042);
  endtask

  task automatic t_master();
    write_cfg(8'h09);
    clear_flags();
    send(1, A_PRI, T_SYNC, 80'hC1, 16'h0101, 64'h3000);
    check("R1 tx sync irq", tx_irq, 1);
    check("R1 tx ts", tx_cap_ts, 64'h3000);
    send(0, A_PRI, T_SYNC, 80'hC2, 16'h0102, 64'h3100);
    check("R1 rx sync ignored", rx_irq, 0);
    send(0, A_PRI, T_DREQ, 80'hC3, 16'h0103, 64'h3200);
    check("R1 rx dreq irq", rx_irq, 1);
    check("R1 rx srcid", rx_cap_srcid, 80'hC3);
  endtask

  task automatic t_addr(input logic [7:0] cfgv, input logic [47:0] hit_da, input string req);
    write_cfg(cfgv);
    clear_flags();
    send(0, A_PRI, T_SYNC, 80'h5, 16'h0500, 64'h4000);
    check({req, " default addr rejected"}, rx_irq, 0);
    send(0, hit_da, T_SYNC, 80'h6, 16'h0600, 64'h4100);
    check({req, " enabled addr accepted"}, rx_irq, 1);
    check({req, " seq"}, rx_cap_seq, 16'h0600);
  endtask

  task automatic t_filters();
    t_addr(8'h10, A_ALT1, "R3 alt1");
    t_addr(8'h20, A_ALT2, "R3 alt2");
    t_addr(8'h40, A_ALT3, "R3 alt3");
    @(negedge clk); aux_we = 1; aux_wdata = A_AUX;
    @(negedge clk); aux_we = 0;
    t_addr(8'h80, A_AUX, "R3 aux");
    write_cfg(8'hF8);
    clear_flags();
    send(0, 48'h01005E000185, T_SYNC, 80'h7, 16'h0700, 64'h4200);
    check("R3 nonmatching addr", rx_irq, 0);
    send(0, A_PRI, 4'h8, 80'h8, 16'h0800, 64'h4300);
    check("R9 non-event type", rx_irq, 0);
    send(0, A_PRI, T_SYNC, 80'h9, 16'h0900, 64'h4400, 30);
    send(0, A_PRI, 4'h2, 80'h9, 16'h0901, 64'h4500);
    check("R9 truncated frame", rx_irq, 0);
    check("R9 seq unchanged", rx_cap_seq, 16'h0600);
    send(0, A_PRI, T_SYNC, 80'hA, 16'h0A00, 64'h4600);
    check("R9 full frame after truncation", rx_cap_seq, 16'h0A00);
  endtask

  task automatic t_lock();
    write_cfg(8'h0E);
    clear_flags();
    send(0, A_PRI, T_SYNC, 80'hD0, 16'd100, 64'h5000);
    send(0, A_PRI, T_SYNC, 80'hD1, 16'd101, 64'h5100);
    check("R7 rx lock seq held", rx_cap_seq, 16'd100);
    check("R7 rx lock ts held", rx_cap_ts, 64'h5000);
    check("R7 rx lock srcid held", rx_cap_srcid, 80'hD0);
    check("R7 rx irq", rx_irq, 1);
    write_cfg(8'h0C);
    clear_flags();
    send(1, A_PRI, T_DREQ, 80'hE0, 16'd200, 64'h6000);
    send(1, A_PRI, T_DREQ, 80'hE1, 16'd201, 64'h6100);
    check("R7 tx lock seq held", tx_cap_seq, 16'd200);
    send(0, A_PRI, T_SYNC, 80'hF0, 16'd300, 64'h7000);
    send(0, A_PRI, T_SYNC, 80'hF1, 16'd301, 64'h7100);
    check("R8 rx overwrite seq", rx_cap_seq, 16'd301);
    check("R8 rx overwrite ts", rx_cap_ts, 64'h7100);
    check("R8 rx irq stays", rx_irq, 1);
    send(0, A_PRI, T_SYNC, 80'hF2, 16'd302, 64'h7200, 46, 1);
    check("R6 capture beats clear", rx_irq, 1);
    check("R6 capture with clear seq", rx_cap_seq, 16'd302);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_slave_default();
    t_master();
    t_filters();
    t_lock();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule